// File: doc/BRIEF.md
# Byte-Addressable General Register File

This block holds eight 16-bit registers for a small processor datapath. Four of them are general registers (accumulator, count, data, base). Each of these can also be used as two independent 8-bit halves. The other four are pointer and index registers (stack pointer, base pointer, source index, destination index), which are word-only. The block has two combinational read ports and one synchronous write port. Every port takes a 3-bit selector and a byte/word flag.

A loop helper works on the count register. It lowers the count by one at the clock edge and tells in the same cycle whether the result is zero. The decrement touches no other register or state. The instruction decoder and the ALU sit outside this block and drive its selectors.

Top module: `gpr_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all eight registers are cleared to zero.
- R2: A word write (`wr_en`=1, `wr_byte`=0) loads all 16 bits of `wr_data` into the register picked by `wr_sel`. The codes are: 0 accumulator, 1 count, 2 data, 3 base, 4 stack pointer, 5 base pointer, 6 source index, 7 destination index.
- R3: A byte write (`wr_byte`=1) loads `wr_data[7:0]` into one half and leaves the other half unchanged. Codes 0..3 pick bits 7:0 and codes 4..7 pick bits 15:8, in the order accumulator, count, data, base.
- R4: A word read returns the whole selected register, using the R2 codes. The two read ports are independent.
- R5: A byte read returns the half picked by the R3 codes on bits 7:0 of the port, with bits 15:8 at zero.
- R6: The pointer and index registers have no byte access. Byte codes 4..7 reach the general registers' high halves and never a pointer or index register.
- R7: A read of a register written in the same cycle returns the old value. The new value appears from the next cycle.
- R8: `loop_en` lowers the count register by one at the clock edge, wrapping 0 to 0xFFFF. No other register changes.
- R9: `loop_zero` is high during a cycle with `loop_en` exactly when the count register holds 1, that is, when the decrement ends at zero. It is low otherwise.
- R10: When a write of either width hits the count register in the same cycle as `loop_en`, the write is applied and the decrement is dropped.
- R11: With neither a write nor a loop request, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd0_sel | input | 3 | Read port 0 selector |
| rd0_byte | input | 1 | Read port 0 byte access |
| rd0_data | output | 16 | Read port 0 data |
| rd1_sel | input | 3 | Read port 1 selector |
| rd1_byte | input | 1 | Read port 1 byte access |
| rd1_data | output | 16 | Read port 1 data |
| wr_en | input | 1 | Write request |
| wr_byte | input | 1 | Write is a byte write |
| wr_sel | input | 3 | Write selector |
| wr_data | input | 16 | Write data; bits 7:0 only for byte writes |
| loop_en | input | 1 | Decrement-and-test request on the count register |
| loop_zero | output | 1 | Decrement in this cycle ends at zero |

## Verification
The hardest case to reach from the ports is a collision on the count register: a loop request and a write to the count register, word or half, in the same cycle. The stimulus first sets the count register to a known value with a word write. It then drives `loop_en` together with a word write and, separately, together with a byte write to the low half. It reads the register back to show that the decrement was dropped and the untouched half kept its value. Half preservation and the absence of write-through are shown the same way. Known words are loaded first, then single halves are overwritten, and the result is read back both before and after the write edge.

// File: rtl/gpr_pkg.sv
// Package: shared sizes and register identifiers for the register file.
// Assumes a 3-bit selector space of eight registers, four of them byte-splittable.
package gpr_pkg;
    localparam int SEL_W   = 3;
    localparam int NREG    = 8;
    localparam int NGEN    = 4;
    localparam int CNT_IDX = 1;

    typedef enum logic [SEL_W-1:0] {
        REG_ACC = 3'd0,
        REG_CNT = 3'd1,
        REG_DAT = 3'd2,
        REG_BAS = 3'd3,
        REG_SPT = 3'd4,
        REG_BPT = 3'd5,
        REG_SRC = 3'd6,
        REG_DST = 3'd7
    } reg_id_e;
endpackage

// File: rtl/gpr_wr_decode.sv
// Write decoder: turns selector and width flag into per-register half enables
// and the data for each half. Assumes byte codes put the half choice in the top bit.
module gpr_wr_decode #(
    parameter int NREG   = 8,
    parameter int SEL_W  = 3,
    parameter int WORD_W = 16
) (
    input  logic                  wr_en,
    input  logic                  wr_byte,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [WORD_W-1:0]     wr_data,
    output logic [NREG-1:0]       lo_we,
    output logic [NREG-1:0]       hi_we,
    output logic [WORD_W/2-1:0]   lo_val,
    output logic [WORD_W/2-1:0]   hi_val
);
    localparam int HALF_W = WORD_W / 2;

    logic [SEL_W-1:0] gen_idx;

    // Purpose: index of the general register named by a byte code.
    always_comb begin
        gen_idx = wr_sel;
        gen_idx[SEL_W-1] = 1'b0;
    end

    // Purpose: raise the half enables the request touches.
    always_comb begin
        lo_we = '0;
        hi_we = '0;
        if (wr_en) begin
            if (!wr_byte) begin
                lo_we[wr_sel] = 1'b1;
                hi_we[wr_sel] = 1'b1;
            end else if (wr_sel[SEL_W-1]) begin
                hi_we[gen_idx] = 1'b1;
            end else begin
                lo_we[gen_idx] = 1'b1;
            end
        end
    end

    // Purpose: route the write data to each half.
    always_comb begin
        lo_val = wr_data[HALF_W-1:0];
        hi_val = wr_byte ? wr_data[HALF_W-1:0] : wr_data[WORD_W-1:HALF_W];
    end
endmodule

// File: rtl/gpr_loop_unit.sv
// Loop helper: computes the decremented count and the zero test.
// Assumes a write to the count register in the same cycle takes priority.
module gpr_loop_unit #(
    parameter int WORD_W = 16
) (
    input  logic              loop_en,
    input  logic              cnt_wr_hit,
    input  logic [WORD_W-1:0] cnt_q,
    output logic              dec_en,
    output logic [WORD_W-1:0] dec_val,
    output logic              loop_zero
);
    // Purpose: decrement value, its enable and the ends-at-zero flag.
    always_comb begin
        dec_val   = cnt_q - WORD_W'(1);
        dec_en    = loop_en && !cnt_wr_hit;
        loop_zero = loop_en && (cnt_q == WORD_W'(1));
    end
endmodule

// File: rtl/gpr_store.sv
// Register storage: eight words, each split into two byte-enabled halves.
// Assumes enables come already decoded; only the count register accepts a decrement.
module gpr_store #(
    parameter int NREG    = 8,
    parameter int WORD_W  = 16,
    parameter int CNT_IDX = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NREG-1:0]              lo_we,
    input  logic [NREG-1:0]              hi_we,
    input  logic [WORD_W/2-1:0]          lo_val,
    input  logic [WORD_W/2-1:0]          hi_val,
    input  logic                         dec_en,
    input  logic [WORD_W-1:0]            dec_val,
    output logic [NREG-1:0][WORD_W-1:0]  regs_q
);
    localparam int HALF_W = WORD_W / 2;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam bit IS_CNT = (i == CNT_IDX);
        logic [HALF_W-1:0] lo_q, hi_q;

        // Purpose: low half update from reset, write or decrement.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
            end else if (lo_we[i]) begin
                lo_q <= lo_val;
            end else if (IS_CNT && dec_en && !hi_we[i]) begin
                lo_q <= dec_val[HALF_W-1:0];
            end
        end

        // Purpose: high half update from reset, write or decrement.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q <= '0;
            end else if (hi_we[i]) begin
                hi_q <= hi_val;
            end else if (IS_CNT && dec_en && !lo_we[i]) begin
                hi_q <= dec_val[WORD_W-1:HALF_W];
            end
        end

        assign regs_q[i] = {hi_q, lo_q};
    end
endmodule

// File: rtl/gpr_rd_port.sv
// Read port: combinational word or zero-extended byte view of the registers.
// Assumes byte codes 0..3 pick low halves and 4..7 high halves of the general registers.
module gpr_rd_port #(
    parameter int NREG   = 8,
    parameter int SEL_W  = 3,
    parameter int WORD_W = 16
) (
    input  logic [NREG-1:0][WORD_W-1:0] regs_q,
    input  logic [SEL_W-1:0]            sel,
    input  logic                        byte_acc,
    output logic [WORD_W-1:0]           data
);
    localparam int HALF_W = WORD_W / 2;

    logic [SEL_W-1:0]  gen_idx;
    logic [WORD_W-1:0] gen_word;

    // Purpose: pick the word or the half and zero-extend a half.
    always_comb begin
        gen_idx = sel;
        gen_idx[SEL_W-1] = 1'b0;
        gen_word = regs_q[gen_idx];
        data = '0;
        if (!byte_acc) begin
            data = regs_q[sel];
        end else if (sel[SEL_W-1]) begin
            data[HALF_W-1:0] = gen_word[WORD_W-1:HALF_W];
        end else begin
            data[HALF_W-1:0] = gen_word[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/gpr_bank.sv
// Top: register file with two read ports, one write port and a count-loop helper.
// Assumes the selector encoding of gpr_pkg; reads are combinational and show pre-edge state.
module gpr_bank
    import gpr_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        rd0_sel,
    input  logic              rd0_byte,
    output logic [WORD_W-1:0] rd0_data,
    input  logic [2:0]        rd1_sel,
    input  logic              rd1_byte,
    output logic [WORD_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic              wr_byte,
    input  logic [2:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              loop_en,
    output logic              loop_zero
);
    localparam int HALF_W = WORD_W / 2;
    localparam int NRD    = 2;

    logic [NREG-1:0]             lo_we, hi_we;
    logic [HALF_W-1:0]           lo_val, hi_val;
    logic                        dec_en;
    logic [WORD_W-1:0]           dec_val;
    logic [NREG-1:0][WORD_W-1:0] regs_q;
    logic                        cnt_wr_hit;
    logic [NRD-1:0][SEL_W-1:0]   rd_sel;
    logic [NRD-1:0]              rd_byte;
    logic [NRD-1:0][WORD_W-1:0]  rd_data;

    gpr_wr_decode #(.NREG(NREG), .SEL_W(SEL_W), .WORD_W(WORD_W)) u_dec (
        .wr_en(wr_en), .wr_byte(wr_byte), .wr_sel(wr_sel), .wr_data(wr_data),
        .lo_we(lo_we), .hi_we(hi_we), .lo_val(lo_val), .hi_val(hi_val)
    );

    // Purpose: flag a write that lands on either half of the count register.
    always_comb cnt_wr_hit = lo_we[CNT_IDX] || hi_we[CNT_IDX];

    gpr_loop_unit #(.WORD_W(WORD_W)) u_loop (
        .loop_en(loop_en), .cnt_wr_hit(cnt_wr_hit), .cnt_q(regs_q[CNT_IDX]),
        .dec_en(dec_en), .dec_val(dec_val), .loop_zero(loop_zero)
    );

    gpr_store #(.NREG(NREG), .WORD_W(WORD_W), .CNT_IDX(CNT_IDX)) u_store (
        .clk(clk), .rst_n(rst_n), .lo_we(lo_we), .hi_we(hi_we),
        .lo_val(lo_val), .hi_val(hi_val), .dec_en(dec_en), .dec_val(dec_val),
        .regs_q(regs_q)
    );

    assign rd_sel  = {rd1_sel, rd0_sel};
    assign rd_byte = {rd1_byte, rd0_byte};

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        gpr_rd_port #(.NREG(NREG), .SEL_W(SEL_W), .WORD_W(WORD_W)) u_rd (
            .regs_q(regs_q), .sel(rd_sel[p]), .byte_acc(rd_byte[p]), .data(rd_data[p])
        );
    end

    assign rd0_data = rd_data[0];
    assign rd1_data = rd_data[1];
endmodule

// File: rtl/gpr_bank_chk.sv
// Checker: temporal properties of the register file, bound to gpr_bank.
// Assumes it sees the stored words through the top's regs_q.
module gpr_bank_chk #(
    parameter int WORD_W = 16,
    parameter int NREG   = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic                        wr_byte,
    input logic [2:0]                  wr_sel,
    input logic [WORD_W-1:0]           wr_data,
    input logic                        loop_en,
    input logic                        loop_zero,
    input logic                        rd0_byte,
    input logic [WORD_W-1:0]           rd0_data,
    input logic                        rd1_byte,
    input logic [WORD_W-1:0]           rd1_data,
    input logic [NREG-1:0][WORD_W-1:0] regs_q
);
    localparam int HALF_W = WORD_W / 2;

    logic cnt_hit;
    logic [2:0] gidx;
    // Purpose: recompute from the ports whether a write lands on the count register.
    always_comb begin
        gidx    = {1'b0, wr_sel[1:0]};
        cnt_hit = wr_en && (wr_byte ? (wr_sel[1:0] == 2'd1) : (wr_sel == 3'd1));
    end

    AST_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_byte |=> regs_q[$past(wr_sel)] == $past(wr_data)); // R2
    AST_BYTE_LO_KEEP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_byte && !wr_sel[2] |=>
        regs_q[$past(gidx)][WORD_W-1:HALF_W] == $past(regs_q[gidx][WORD_W-1:HALF_W])); // R3
    AST_BYTE_HI_KEEP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_byte && wr_sel[2] |=>
        regs_q[$past(gidx)][HALF_W-1:0] == $past(regs_q[gidx][HALF_W-1:0])); // R3
    AST_BYTE_ZERO_EXT0: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_byte |-> rd0_data[WORD_W-1:HALF_W] == '0); // R5
    AST_BYTE_ZERO_EXT1: assert property (@(posedge clk) disable iff (!rst_n)
        rd1_byte |-> rd1_data[WORD_W-1:HALF_W] == '0); // R5
    AST_BYTE_SPARES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_byte |=> regs_q[7:4] == $past(regs_q[7:4])); // R6
    AST_LOOP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en && !cnt_hit |=> regs_q[1] == $past(regs_q[1]) - WORD_W'(1)); // R8
    AST_LOOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        loop_zero && !cnt_hit |=> regs_q[1] == '0); // R9
    AST_LOOP_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en && wr_en && !wr_byte && wr_sel == 3'd1 |=> regs_q[1] == $past(wr_data)); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !loop_en |=> $stable(regs_q)); // R11
endmodule

bind gpr_bank gpr_bank_chk #(.WORD_W(WORD_W), .NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte), .wr_sel(wr_sel),
    .wr_data(wr_data), .loop_en(loop_en), .loop_zero(loop_zero),
    .rd0_byte(rd0_byte), .rd0_data(rd0_data), .rd1_byte(rd1_byte), .rd1_data(rd1_data),
    .regs_q(regs_q)
);

// File: tb/tb_gpr_bank.sv
// Bench: vector table walked by one loop, then directed reset and corner tests.
module tb_gpr_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 27;

    typedef struct packed {
        logic [3:0]  req;
        logic        we;
        logic        wb;
        logic [2:0]  ws;
        logic [15:0] wd;
        logic        lp;
        logic [2:0]  rs;
        logic        rb;
        logic [15:0] ex;
    } vec_t;

    // req, we, wb, ws, wd, lp, rs, rb, expected read on port 0 after the edge
    localparam vec_t VEC [NVEC] = '{
        '{4'd2,  1'b1, 1'b0, 3'd0, 16'h1234, 1'b0, 3'd0, 1'b0, 16'h1234}, // R2
        '{4'd3,  1'b1, 1'b1, 3'd4, 16'h00AB, 1'b0, 3'd0, 1'b0, 16'hAB34}, // R3
        '{4'd3,  1'b1, 1'b1, 3'd0, 16'h99CD, 1'b0, 3'd0, 1'b0, 16'hABCD}, // R3
        '{4'd5,  1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd4, 1'b1, 16'h00AB}, // R5
        '{4'd5,  1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd0, 1'b1, 16'h00CD}, // R5
        '{4'd2,  1'b1, 1'b0, 3'd3, 16'h0F0E, 1'b0, 3'd7, 1'b1, 16'h000F}, // R2
        '{4'd3,  1'b1, 1'b1, 3'd3, 16'h0055, 1'b0, 3'd3, 1'b0, 16'h0F55}, // R3
        '{4'd2,  1'b1, 1'b0, 3'd4, 16'hBEEF, 1'b0, 3'd4, 1'b0, 16'hBEEF}, // R2
        '{4'd6,  1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd4, 1'b1, 16'h00AB}, // R6
        '{4'd2,  1'b1, 1'b0, 3'd1, 16'h0003, 1'b0, 3'd1, 1'b0, 16'h0003}, // R2
        '{4'd8,  1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 3'd1, 1'b0, 16'h0002}, // R8
        '{4'd8,  1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 3'd1, 1'b0, 16'h0001}, // R8
        '{4'd8,  1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 3'd1, 1'b0, 16'h0000}, // R8
        '{4'd8,  1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 3'd1, 1'b0, 16'hFFFF}, // R8 wrap
        '{4'd3,  1'b1, 1'b1, 3'd5, 16'h0012, 1'b0, 3'd1, 1'b0, 16'h12FF}, // R3
        '{4'd10, 1'b1, 1'b0, 3'd1, 16'h0100, 1'b1, 3'd1, 1'b0, 16'h0100}, // R10
        '{4'd10, 1'b1, 1'b1, 3'd1, 16'h0077, 1'b1, 3'd1, 1'b0, 16'h0177}, // R10
        '{4'd8,  1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 3'd3, 1'b0, 16'h0F55}, // R8 others kept
        '{4'd2,  1'b1, 1'b0, 3'd7, 16'h8001, 1'b0, 3'd7, 1'b0, 16'h8001}, // R2
        '{4'd2,  1'b1, 1'b0, 3'd6, 16'h7FFE, 1'b0, 3'd6, 1'b0, 16'h7FFE}, // R2
        '{4'd2,  1'b1, 1'b0, 3'd5, 16'h1111, 1'b0, 3'd5, 1'b0, 16'h1111}, // R2
        '{4'd2,  1'b1, 1'b0, 3'd2, 16'h2222, 1'b0, 3'd2, 1'b0, 16'h2222}, // R2
        '{4'd3,  1'b1, 1'b1, 3'd6, 16'h0033, 1'b0, 3'd2, 1'b0, 16'h3322}, // R3
        '{4'd3,  1'b1, 1'b1, 3'd2, 16'h0044, 1'b0, 3'd2, 1'b0, 16'h3344}, // R3
        '{4'd11, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd0, 1'b0, 16'hABCD}, // R11
        '{4'd11, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd4, 1'b0, 16'hBEEF}, // R11
        '{4'd6,  1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd6, 1'b0, 16'h7FFE}  // R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd0_sel = '0, rd1_sel = '0, wr_sel = '0;
    logic        rd0_byte = 1'b0, rd1_byte = 1'b0, wr_en = 1'b0, wr_byte = 1'b0, loop_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd0_data, rd1_data;
    logic        loop_zero;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    gpr_bank dut (
        .clk(clk), .rst_n(rst_n), .rd0_sel(rd0_sel), .rd0_byte(rd0_byte), .rd0_data(rd0_data),
        .rd1_sel(rd1_sel), .rd1_byte(rd1_byte), .rd1_data(rd1_data), .wr_en(wr_en),
        .wr_byte(wr_byte), .wr_sel(wr_sel), .wr_data(wr_data), .loop_en(loop_en),
        .loop_zero(loop_zero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_byte = 1'b0; loop_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic word_write(input logic [2:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_byte = 1'b0; wr_sel = s; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    initial begin
        idle();
        do_reset();
        // R1: every register reads zero after reset, on both ports
        for (int i = 0; i < 8; i++) begin
            rd0_sel = 3'(i); rd1_sel = 3'(7 - i); #1;
            check("R1 port0", rd0_data, 16'h0000);
            check("R1 port1", rd1_data, 16'h0000);
        end

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            wr_en = VEC[v].we; wr_byte = VEC[v].wb; wr_sel = VEC[v].ws; wr_data = VEC[v].wd;
            loop_en = VEC[v].lp; rd0_sel = VEC[v].rs; rd0_byte = VEC[v].rb;
            rd1_sel = 3'd0; rd1_byte = 1'b0;
            @(posedge clk);
            @(negedge clk);
            idle();
            #1;
            check($sformatf("R%0d vec%0d", VEC[v].req, v), rd0_data, VEC[v].ex);
        end

        // R4: both ports read different registers at once
        rd0_sel = 3'd4; rd0_byte = 1'b0; rd1_sel = 3'd2; rd1_byte = 1'b0; #1;
        check("R4 port0", rd0_data, 16'hBEEF);
        check("R4 port1", rd1_data, 16'h3344);

        // R7: same-cycle read shows the old value, next cycle the new one
        rd1_sel = 3'd7; rd1_byte = 1'b0;
        wr_en = 1'b1; wr_byte = 1'b0; wr_sel = 3'd7; wr_data = 16'h5A5A; #1;
        check("R7 before edge", rd1_data, 16'h8001);
        @(posedge clk);
        @(negedge clk);
        idle(); #1;
        check("R7 after edge", rd1_data, 16'h5A5A);

        // R9: loop_zero high when the count holds 1, low when it holds 2 or 0
        word_write(3'd1, 16'h0001);
        loop_en = 1'b1; #1;
        check("R9 count one", {15'd0, loop_zero}, 16'h0001);
        @(posedge clk);
        @(negedge clk); #1;
        check("R9 count zero", {15'd0, loop_zero}, 16'h0000);
        idle(); #1;
        check("R9 no request", {15'd0, loop_zero}, 16'h0000);
        word_write(3'd1, 16'h0002);
        loop_en = 1'b1; #1;
        check("R9 count two", {15'd0, loop_zero}, 16'h0000);
        @(posedge clk);
        @(negedge clk);
        idle();

        // R1: reset in mid-run clears loaded registers
        do_reset();
        rd0_sel = 3'd4; rd1_sel = 3'd0; #1;
        check("R1 mid-run port0", rd0_data, 16'h0000);
        check("R1 mid-run port1", rd1_data, 16'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule